// File: doc/BRIEF.md
# ECC Error Address Capture Register

This block is a 32-bit status and control register for a memory controller's read path. The ECC checker raises a single-bit (corrected) or multi-bit (uncorrectable) error strobe. With the strobe it gives the failing 32-bit address and the 8-bit syndrome. The register logs only the first event. It keeps the upper 19 address bits, the syndrome and one status flag that names the error class. While a flag is set the record stays frozen, so software reads the error that happened first.

Software re-arms logging by writing ones to both status bits in one write. Three control bits live in the same word. Two of them enable level outputs: an NMI request for a corrected error and a bus-error request for an uncorrectable one. The third turns off the scrub request, which tells the controller to write corrected data back on a corrected read.

Register layout (read data): bit 31 scrub disable (RW), bits 30:12 address bits 31:13 (RO), bits 11:4 syndrome (RO), bit 3 bus-error enable (RW), bit 2 NMI enable (RW), bit 1 multi-bit flag (W1C), bit 0 single-bit flag (W1C). Byte enable bit n gates write-data bits 8n+7:8n.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset the read data is 0 and nmi_o and bus_err_o are low.
- R2: With no flag set, a single-bit strobe sets read bit 0, stores address bits 31:13 in read bits 30:12 and the syndrome in read bits 11:4, all visible one cycle after the strobe.
- R3: With no flag set, a multi-bit strobe sets read bit 1 and captures address and syndrome in the same way as R2.
- R4: When both strobes arrive in the same cycle with no flag set, only bit 1 (multi-bit) is set.
- R5: While either flag is set, further strobes change neither the flags, the address field nor the syndrome field.
- R6: A write clears the flags only when byte enable 0 is set and write-data bits 1:0 are both 1. A write with only one of those bits set, or with both at 0, leaves the flags unchanged.
- R7: A clearing write that coincides with a strobe captures the new error in that same cycle.
- R8: Bit 31 is written through byte enable 3, and bits 3:2 through byte enable 0. Writes to bits 30:4 have no effect.
- R9: nmi_o is high exactly while bit 0 and bit 2 are both set.
- R10: bus_err_o is high exactly while bit 1 and bit 3 are both set.
- R11: scrub_en_o is high in the same cycle as a single-bit strobe without a multi-bit strobe, and only while bit 31 is 0. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sbe_i | input | 1 | Single-bit (corrected) error strobe |
| mbe_i | input | 1 | Multi-bit (uncorrectable) error strobe |
| err_addr_i | input | 32 | Failing address |
| err_syn_i | input | 8 | Syndrome of the failing read |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 4 | Byte enables of the write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Register read data |
| nmi_o | output | 1 | NMI request level |
| bus_err_o | output | 1 | Bus-error request level |
| scrub_en_o | output | 1 | Write corrected data back for the current read |

## Verification
The clearing write and a fresh error strobe can fall in one cycle. In that cycle the register must drop the old record and take the new one, not lose it. The bench provokes this case with a directed step that puts a both-bits clear beside a multi-bit strobe. Random traffic also keeps clearing writes and strobes frequent, so the two collide many times. A bench model applies the clear first and the capture second, and every cycle the read data is compared against that model.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 32;
  localparam int SYN_W     = 8;
  localparam int ADDR_HI_W = 19;
  localparam int BE_W      = REG_W / 8;

  localparam int SBE_B       = 0;
  localparam int MBE_B       = 1;
  localparam int NMI_EN_B    = 2;
  localparam int BERR_EN_B   = 3;
  localparam int SYN_LSB     = 4;
  localparam int AHI_LSB     = SYN_LSB + SYN_W;
  localparam int SCRUB_DIS_B = AHI_LSB + ADDR_HI_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SBE  = 2'b01,
    ST_MBE  = 2'b10
  } stat_e;

  typedef struct packed {
    logic scrub_dis;
    logic berr_en;
    logic nmi_en;
  } ctrl_t;
endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BE_W-1:0]  wr_be_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ctrl_t            ctrl_o
);
  localparam int NB = 3;
  localparam int POS [NB] = '{SCRUB_DIS_B, BERR_EN_B, NMI_EN_B};

  logic [NB-1:0] bits_q;

  for (genvar g = 0; g < NB; g++) begin : g_bit
    localparam int P = POS[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       bits_q[NB-1-g] <= 1'b0;
      else if (wr_en_i && wr_be_i[P/8])  bits_q[NB-1-g] <= wr_data_i[P];
    end
  end

  assign ctrl_o = ctrl_t'(bits_q);

  p_lane_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_be_i[SCRUB_DIS_B/8]) |=> $stable(ctrl_o.scrub_dis));
endmodule

// File: rtl/ecc_cap_log.sv
module ecc_cap_log
  import ecc_cap_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sbe_i,
  input  logic                 mbe_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [SYN_W-1:0]     syn_i,
  input  logic                 clr_i,
  output stat_e                stat_o,
  output logic [ADDR_HI_W-1:0] addr_hi_o,
  output logic [SYN_W-1:0]     syn_o
);
  stat_e                stat_q;
  logic [ADDR_HI_W-1:0] addr_q;
  logic [SYN_W-1:0]     syn_q;
  logic                 err, armed;

  assign err   = sbe_i | mbe_i;
  assign armed = (stat_q == ST_IDLE) | clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= ST_IDLE;
      addr_q <= '0;
      syn_q  <= '0;
    end else if (err && armed) begin
      stat_q <= mbe_i ? ST_MBE : ST_SBE;
      addr_q <= addr_i[ADDR_W-1 -: ADDR_HI_W];
      syn_q  <= syn_i;
    end else if (clr_i) begin
      stat_q <= ST_IDLE;
    end
  end

  assign stat_o    = stat_q;
  assign addr_hi_o = addr_q;
  assign syn_o     = syn_q;

  p_hold_record_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q != ST_IDLE && !clr_i) |=> ($stable(addr_q) && $stable(syn_q) && $stable(stat_q)));
  p_mbe_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_i && mbe_i && stat_q == ST_IDLE) |=> stat_q == ST_MBE);
  p_clear_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !err) |=> stat_q == ST_IDLE);
  p_flags_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q != 2'b11);
endmodule

// File: rtl/ecc_cap_irq.sv
module ecc_cap_irq
  import ecc_cap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  stat_e stat_i,
  input  ctrl_t ctrl_i,
  input  logic  sbe_i,
  input  logic  mbe_i,
  output logic  nmi_o,
  output logic  bus_err_o,
  output logic  scrub_en_o
);
  assign nmi_o      = (stat_i == ST_SBE) & ctrl_i.nmi_en;
  assign bus_err_o  = (stat_i == ST_MBE) & ctrl_i.berr_en;
  assign scrub_en_o = sbe_i & ~mbe_i & ~ctrl_i.scrub_dis;

  p_no_scrub_mbe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbe_i |-> !scrub_en_o);
  p_irq_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nmi_o && bus_err_o));
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sbe_i,
  input  logic        mbe_i,
  input  logic [31:0] err_addr_i,
  input  logic [7:0]  err_syn_i,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_be_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        nmi_o,
  output logic        bus_err_o,
  output logic        scrub_en_o
);
  ctrl_t                ctrl;
  stat_e                stat;
  logic [ADDR_HI_W-1:0] addr_hi;
  logic [SYN_W-1:0]     syn;
  logic                 clr;

  // both flags must be written 1 together to re-arm
  assign clr = wr_en_i & wr_be_i[0] & wr_data_i[MBE_B] & wr_data_i[SBE_B];

  ecc_cap_ctrl i_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_be_i, .wr_data_i, .ctrl_o(ctrl)
  );

  ecc_cap_log i_log (
    .clk_i, .rst_ni, .sbe_i, .mbe_i,
    .addr_i(err_addr_i), .syn_i(err_syn_i), .clr_i(clr),
    .stat_o(stat), .addr_hi_o(addr_hi), .syn_o(syn)
  );

  ecc_cap_irq i_irq (
    .clk_i, .rst_ni, .stat_i(stat), .ctrl_i(ctrl), .sbe_i, .mbe_i,
    .nmi_o, .bus_err_o, .scrub_en_o
  );

  assign rd_data_o = {ctrl.scrub_dis, addr_hi, syn, ctrl.berr_en, ctrl.nmi_en, stat};

  p_clear_and_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && (sbe_i || mbe_i)) |=> rd_data_o[1:0] != 2'b00);
  p_nmi_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (rd_data_o[NMI_EN_B] && rd_data_o[SBE_B]));
  p_berr_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (rd_data_o[BERR_EN_B] && rd_data_o[MBE_B]));
endmodule

// File: tb/test_ecc_err_capture.sv
module test_ecc_err_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sbe_i = 1'b0, mbe_i = 1'b0;
  logic [31:0] err_addr_i = '0;
  logic [7:0]  err_syn_i = '0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_be_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        nmi_o, bus_err_o, scrub_en_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit        m_sd, m_be, m_ne, m_mf, m_sf;
  bit [18:0] m_ah;
  bit [7:0]  m_syn;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ecc_err_capture i_ecc_err_capture (.*);

  function automatic bit [31:0] exp_rd();
    return {m_sd, m_ah, m_syn, m_be, m_ne, m_mf, m_sf};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_upd(bit s, bit m, bit [31:0] a, bit [7:0] y, bit we, bit [3:0] be, bit [31:0] wd);
    bit clr = we && be[0] && wd[1] && wd[0];
    bit idle = !(m_sf || m_mf) || clr;
    if (clr) begin m_sf = 0; m_mf = 0; end
    if ((s || m) && idle) begin
      m_mf = m; m_sf = !m; m_ah = a[31:13]; m_syn = y;
    end
    if (we && be[3]) m_sd = wd[31];
    if (we && be[0]) begin m_be = wd[3]; m_ne = wd[2]; end
  endtask

  task automatic step(string tag, bit s, bit m, bit [31:0] a, bit [7:0] y,
                      bit we, bit [3:0] be, bit [31:0] wd);
    @(negedge clk_i);
    sbe_i = s; mbe_i = m; err_addr_i = a; err_syn_i = y;
    wr_en_i = we; wr_be_i = be; wr_data_i = wd;
    #1;
    check("R11 scrub", 32'(scrub_en_o), 32'(s && !m && !m_sd));
    @(posedge clk_i);
    model_upd(s, m, a, y, we, be, wd);
    #1;
    sbe_i = 0; mbe_i = 0; wr_en_i = 0;
    check(tag, rd_data_o, exp_rd());
    check("R9 nmi", 32'(nmi_o), 32'(m_sf && m_ne));
    check("R10 bus_err", 32'(bus_err_o), 32'(m_mf && m_be));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4211));
    #(CLK_PERIOD * 3);
    check("R1 reset rd", rd_data_o, 32'h0);
    check("R1 reset irq", {30'h0, nmi_o, bus_err_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R8: enables via lanes, RO bits ignored
    step("R8 ctrl write", 0, 0, 0, 0, 1, 4'b0001, 32'h7FFF_FFFC);
    step("R8 lane3 scrub", 0, 0, 0, 0, 1, 4'b1000, 32'h8000_0000);
    step("R11 scrub blocked", 1, 0, 32'hAAAA_0000, 8'h11, 0, 0, 0);
    step("R6 clear", 0, 0, 0, 0, 1, 4'b1001, 32'h0000_000F);
    // R2 single-bit capture, NMI enabled
    step("R2 sbe capture", 1, 0, 32'hDEAD_BEEF, 8'h5A, 0, 0, 0);
    // R5 later errors frozen out
    step("R5 hold mbe", 0, 1, 32'h1234_5678, 8'hC3, 0, 0, 0);
    step("R5 hold sbe", 1, 0, 32'h0000_2000, 8'h01, 0, 0, 0);
    // R6 partial and zero writes ignored
    step("R6 one bit", 0, 0, 0, 0, 1, 4'b0001, 32'h0000_000D);
    step("R6 other bit", 0, 0, 0, 0, 1, 4'b0001, 32'h0000_000E);
    step("R6 lane off", 0, 0, 0, 0, 1, 4'b1110, 32'h0000_000F);
    step("R6 zero", 0, 0, 0, 0, 1, 4'b0001, 32'h0000_000C);
    // R7 clear with a new error in the same cycle
    step("R7 clear+mbe", 0, 1, 32'hFEDC_A000, 8'h99, 1, 4'b0001, 32'h0000_000F);
    step("R6 clear both", 0, 0, 0, 0, 1, 4'b0001, 32'h0000_000F);
    // R4 simultaneous strobes
    step("R4 both strobes", 1, 1, 32'h8000_4000, 8'hE7, 0, 0, 0);
    step("R6 clear", 0, 0, 0, 0, 1, 4'b0001, 32'h0000_0003);
    // R3 multi-bit with bus-error disabled
    step("R3 mbe capture", 0, 1, 32'h0001_FFFF, 8'h3C, 0, 0, 0);
    step("R10 enable late", 0, 0, 0, 0, 1, 4'b0001, 32'h0000_0008);

    for (int i = 0; i < 3000; i++) begin
      bit [3:0] be = 4'($urandom);
      bit we = ($urandom % 4) == 0;
      bit [31:0] wd = $urandom;
      bit s = ($urandom % 3) == 0;
      bit m = ($urandom % 5) == 0;
      step("R2 R3 R4 R5 R6 R7 R8 rand", s, m, $urandom, 8'($urandom), we, be, wd);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule